// File: doc/BRIEF.md
# Serial Transmit Word Loader

This block sits between a host data bus and a serial word transmitter. The host builds each 31-bit word in two halves. A low-half strobe latches the lower 16 bits from the bus. A following high-half strobe latches the upper 15 bits and commits the complete word to an eight-deep queue. Writes that arrive while the queue is full are dropped without any indication.

While transmit enable is high and the serializer is idle, the block hands the oldest queued word to the serializer with a one-cycle load pulse. It then counts that word as in flight until the serializer reports completion. The ready flag means that every word loaded so far has gone out: the queue is empty and nothing is in flight. It does not mean that the queue has space. If transmit enable falls while a word is in flight, that word is abandoned and is never sent again. An asynchronous master reset clears the queue, the half-word arming and the in-flight state.

Top module: `arinc_tx_loader`

## Requirements
- R1: A low-half strobe latches `bus_in[15:0]`. A later high-half strobe commits the word {`bus_in[14:0]`, latched low half}, with the low half in word bits 15:0. Words are handed out in commit order.
- R2: A high-half strobe with no low-half strobe since the last high-half strobe, or since reset, commits nothing. Each low-half strobe arms exactly one commit.
- R3: `fill` never exceeds 8. A commit attempted while `fill` is 8 at the clock edge is dropped, and the queued words are unchanged.
- R4: `tx_ready` is high exactly when `fill` is 0 and no word is in flight.
- R5: When `tx_en` is high, no word is in flight and `fill` is non-zero, `ser_load` is high in that same cycle with `ser_word` equal to the oldest word. At the next edge that word leaves the queue and becomes in flight.
- R6: A word stays in flight, and `ser_load` stays low, until `ser_done` is sampled high.
- R7: If `tx_en` is low while a word is in flight, that word is abandoned at the edge and is never loaded again.
- R8: A commit and a hand-off at the same edge leave `fill` unchanged and keep the word order.
- R9: When `rst_n` is low, `fill` is 0, the arming is cleared, no word is in flight and `tx_ready` is high.
- R10: When both strobes are high in one cycle, the high-half strobe commits using the previously latched low half. The low-half strobe then latches the new bus value and arms the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| bus_in | input | 16 | Host data bus |
| strobe_lo | input | 1 | Latch low half of word |
| strobe_hi | input | 1 | Latch high half and commit word |
| tx_en | input | 1 | Transmit enable |
| ser_done | input | 1 | Serializer finished the in-flight word |
| ser_load | output | 1 | Hand-off pulse to serializer |
| ser_word | output | 31 | Word handed to serializer |
| tx_ready | output | 1 | All loaded words sent |
| fill | output | 4 | Words waiting in queue (0 to 8) |

## Verification
A corrupted occupancy count shows up on `fill` in the cycle after the faulty edge. It then shows up on `tx_ready` or on a missing or extra `ser_load` once the queue drains. A pointer fault appears as a wrong `ser_word` on the next hand-off. The bench keeps its own queue and compares every hand-off word in the same cycle. Faults in the arming or in-flight state show within one strobe pair or one `ser_done` pulse, as an extra or missing commit or as a repeated or lost word.

// File: rtl/arinc_tx_loader.sv
module arinc_tx_loader #(
  parameter int LO_W  = 16,
  parameter int HI_W  = 15,
  parameter int DEPTH = 8,
  localparam int WORD_W = LO_W + HI_W,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   bus_in,
  input  logic              strobe_lo,
  input  logic              strobe_hi,
  input  logic              tx_en,
  input  logic              ser_done,
  output logic              ser_load,
  output logic [WORD_W-1:0] ser_word,
  output logic              tx_ready,
  output logic [CNT_W-1:0]  fill
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [LO_W-1:0]   lo_q;
  logic              armed, busy;
  logic              commit, push, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign commit   = strobe_hi & armed;
  assign push     = commit & (cnt != CNT_W'(DEPTH));
  assign pop      = tx_en & ~busy & (cnt != '0);
  assign ser_load = pop;
  assign ser_word = mem[rd_ptr];
  assign tx_ready = (cnt == '0) & ~busy;
  assign fill     = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {bus_in[HI_W-1:0], lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      armed  <= 1'b0;
      lo_q   <= '0;
      busy   <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (strobe_lo) begin
        lo_q  <= bus_in;
        armed <= 1'b1;
      end else if (strobe_hi) begin
        armed <= 1'b0;
      end
      if (pop)                       busy <= 1'b1;
      else if (!tx_en || ser_done)   busy <= 1'b0;
    end
  end

endmodule

module arinc_tx_loader_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             strobe_hi,
  input logic             ser_load,
  input logic             tx_ready,
  input logic [CNT_W-1:0] fill
);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  p_load_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> (tx_en && fill != '0));

  p_ready_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (fill == '0 && !ser_load));

  p_single_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> !ser_load);

  p_abort_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && fill == '0 && !strobe_hi) |=> tx_ready);

endmodule

bind arinc_tx_loader arinc_tx_loader_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .strobe_hi(strobe_hi),
  .ser_load(ser_load), .tx_ready(tx_ready), .fill(fill)
);

// File: tb/sim_arinc_tx_loader.sv
module sim_arinc_tx_loader;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_in = '0;
  logic        strobe_lo = 0, strobe_hi = 0, tx_en = 0, ser_done = 0;
  logic        ser_load, tx_ready;
  logic [30:0] ser_word;
  logic [3:0]  fill;

  int n_chk = 0, n_bad = 0;
  logic [30:0] q[$];
  logic        m_armed = 0, m_busy = 0;
  logic [15:0] m_lo = '0;
  logic [30:0] last_load;

  always #(CLK_NS/2) clk = ~clk;

  arinc_tx_loader u0 (.clk, .rst_n, .bus_in, .strobe_lo, .strobe_hi, .tx_en,
    .ser_done, .ser_load, .ser_word, .tx_ready, .fill);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(logic [15:0] hi_bus, logic [15:0] lo);
    return {hi_bus[14:0], lo};
  endfunction

  function automatic logic exp_ready();
    return (q.size() == 0) && !m_busy;
  endfunction

  task automatic step(logic lo, logic hi, logic [15:0] b, logic en, logic dn, string tag);
    logic ld;
    @(negedge clk);
    strobe_lo = lo; strobe_hi = hi; bus_in = b; tx_en = en; ser_done = dn;
    #1;
    ld = en && !m_busy && (q.size() > 0);
    chk(tag, "ser_load", 32'(ser_load), 32'(ld));
    if (ld) begin
      chk(tag, "ser_word", 32'(ser_word), 32'(q[0]));
      last_load = q[0];
    end
    chk(tag, "tx_ready", 32'(tx_ready), 32'(exp_ready()));
    chk(tag, "fill", 32'(fill), 32'(q.size()));
    @(posedge clk);
    if (hi && m_armed && q.size() < DEPTH) begin
      if (ld) void'(q.pop_front());
      q.push_back(mk(b, m_lo));
    end else if (ld) void'(q.pop_front());
    if (ld) m_busy = 1;
    else if (!en || dn) m_busy = 0;
    if (lo) begin m_lo = b; m_armed = 1; end
    else if (hi) m_armed = 0;
  endtask

  task automatic idle(string tag);
    step(0, 0, 16'h0, tx_en, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    strobe_lo = 0; strobe_hi = 0; tx_en = 0; ser_done = 0;
    q.delete(); m_armed = 0; m_busy = 0; m_lo = '0;
    #1;
    chk("R9", "fill in reset", 32'(fill), 0);
    chk("R9", "tx_ready in reset", 32'(tx_ready), 1);
    chk("R9", "ser_load in reset", 32'(ser_load), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    idle("R9");

    // R2: high strobe without arming
    step(0, 1, 16'h1234, 0, 0, "R2");
    idle("R2");
    chk("R2", "fill after unarmed hi", 32'(fill), 0);
    step(1, 0, 16'h0AAA, 0, 0, "R2");
    step(0, 1, 16'h0001, 0, 0, "R2");
    step(0, 1, 16'h0002, 0, 0, "R2");
    idle("R2");
    chk("R2", "single commit per arm", 32'(fill), 1);

    // R3: fill to full and attempt more
    for (int i = 0; i < 9; i++) begin
      step(1, 0, 16'(16'h100 + i), 0, 0, "R3");
      step(0, 1, 16'(16'h7F00 + i), 0, 0, "R3");
    end
    idle("R3");
    chk("R3", "fill at full", 32'(fill), DEPTH);
    chk("R4", "ready low while full", 32'(tx_ready), 0);

    // R1/R4/R5: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 1, 0, "R1");
      step(0, 0, 0, 1, 1, "R4");
    end
    idle("R4");
    chk("R4", "ready after drain", 32'(tx_ready), 1);

    // R10: simultaneous strobes
    step(1, 0, 16'hA5A5, 0, 0, "R10");
    step(1, 1, 16'h3C3C, 0, 0, "R10");
    step(0, 1, 16'h5555, 0, 0, "R10");
    idle("R10");
    chk("R10", "two commits", 32'(fill), 2);
    step(0, 0, 0, 1, 0, "R10");
    chk("R10", "first word", 32'(last_load), 32'(mk(16'h3C3C, 16'hA5A5)));
    step(0, 0, 0, 1, 1, "R10");
    step(0, 0, 0, 1, 0, "R10");
    chk("R10", "second word", 32'(last_load), 32'(mk(16'h5555, 16'h3C3C)));
    step(0, 0, 0, 1, 1, "R10");

    // R6: in flight holds without done
    step(1, 0, 16'h1111, 0, 0, "R6");
    step(0, 1, 16'h2222, 0, 0, "R6");
    step(1, 0, 16'h3333, 0, 0, "R6");
    step(0, 1, 16'h4444, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R6");
    chk("R6", "one left queued", 32'(fill), 1);

    // R7: drop enable while in flight, then next word is the queued one
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, "R7");
    chk("R7", "next word after abort", 32'(last_load), 32'(mk(16'h4444, 16'h3333)));
    step(0, 0, 0, 0, 0, "R7");
    idle("R7");
    chk("R7", "ready after abort", 32'(tx_ready), 1);

    // R8: commit and hand-off at the same edge
    step(1, 0, 16'h0101, 0, 0, "R8");
    step(0, 1, 16'h0202, 0, 0, "R8");
    step(1, 0, 16'h0303, 0, 0, "R8");
    step(0, 1, 16'h0404, 1, 0, "R8");
    chk("R8", "fill unchanged", 32'(fill), 1);
    step(0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 1, 0, "R8");
    chk("R8", "order kept", 32'(last_load), 32'(mk(16'h0404, 16'h0303)));
    step(0, 0, 0, 1, 1, "R8");

    // R9: reset mid-traffic
    step(1, 0, 16'h7777, 0, 0, "R9");
    step(0, 1, 16'h6666, 0, 0, "R9");
    do_reset();
    step(0, 1, 16'h1, 0, 0, "R9");
    idle("R9");
    chk("R9", "arming cleared", 32'(fill), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2] & r[3], r[31:16], (r[6:4] != 0), r[7] & r[8], "R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule